// File: doc/BRIEF.md
# Maskable Control/Status Register Unit

This unit holds a small set of control/status registers in which one register, the enable register, decides whether fields of the others are writable or read-only. A field that is read-only is masked: software reads a constant zero for it, and every value exported to the rest of the core uses that zero. The flip-flops behind a masked field keep running, however. They keep their contents, they accept writes exactly as if the field were open, and when the enable bit is set again the stored value reappears unchanged.

Three fields are covered. The first is a two-bit mode field whose storage only ever holds legal encodings. The second is a one-bit flag. The third is a return-address register whose bit 1 is masked whenever compressed-instruction support is off, which means 32-bit alignment. Access is through a single-port interface: an address, a write strobe and write data, with a combinational read-data output. Writes take effect on the rising clock edge.

Top module: `maskable_csr_unit`

## Requirements
- R1: After reset the enable register reads 7 (all three enables set), and the data register, the return-address register and all exported values read zero.
- R2: When `csr_we` is high at a rising edge, the addressed register is updated at that edge. `csr_rdata` shows the addressed register combinationally from the current state. Address 0 is the enable register, address 1 is the data register and address 2 is the return-address register.
- R3: Enable register bit 0 opens the mode field, which sits at bits [1:0] of address 1. Bit 1 opens the flag, which sits at bit 2 of address 1. While an enable is 0, its field reads 0 at `csr_rdata` and on its exported output.
- R4: A write made while a field is masked updates that field's hidden storage. The written value becomes visible once the field is unmasked.
- R5: Changing an enable bit never alters the stored value of the field it controls.
- R6: The mode field accepts only the values 0, 1 and 3. A write of 2 leaves the stored mode unchanged, and this applies whether the field is masked or not.
- R7: Bit 0 of the return-address register always reads 0 and ignores writes.
- R8: Enable register bit 2 is compressed support. While it is 0, return-address bit 1 reads 0 on `csr_rdata` and on `retpc_eff_o`. The stored bit is retained and reappears when the bit is set again.
- R9: Address 3 is unimplemented. It reads zero, and writes to it change no register.
- R10: The enable register reads back its three bits at [2:0]. All higher bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 2 | Register address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the addressed register |
| mode_eff_o | output | 2 | Effective (visible) mode field |
| flag_eff_o | output | 1 | Effective flag |
| retpc_eff_o | output | 32 | Effective return address |

## Verification
The bench writes fields while they are masked and then unmasks them. A design that cleared hidden state, or that gated writes with the mask, would show zero or a stale value at that point instead of the written one. It sends the illegal mode encoding both while the field is open and while it is masked. A design that legalized only visible writes would later reveal a 2. It also toggles an enable with no data write in between, which catches a design that disturbs storage on a mask change. Finally, it checks that compressed-disable hides return-address bit 1 and that bit 1 returns later, along with the hardwired bit 0 and the unimplemented address.

// File: rtl/csr_mask_pkg.sv
package csr_mask_pkg;
  localparam int unsigned NUM_EN   = 3;
  localparam int unsigned EN_MODE  = 0;
  localparam int unsigned EN_FLAG  = 1;
  localparam int unsigned EN_CMP   = 2;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned FLAG_BIT = 2;

  typedef enum logic [1:0] {
    A_ENABLE  = 2'd0,
    A_DATA    = 2'd1,
    A_RETPC   = 2'd2,
    A_UNUSED  = 2'd3
  } csr_addr_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] v);
    return v != 2'b10;
  endfunction
endpackage

// File: rtl/mask_ctrl.sv
module mask_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R5: enables only move on a write to the enable register
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/hidden_field.sv
module hidden_field #(
  parameter int unsigned W        = 1,
  parameter bit          LEGALIZE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         masked,
  output logic [W-1:0] eff_o
);
  import csr_mask_pkg::*;

  logic [W-1:0] q, d;
  logic         accept;

  generate
    if (LEGALIZE) begin : g_warl
      assign accept = mode_legal(wr_val);
      // R6: hidden storage never takes the illegal code
      p_warl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(q));
    end else begin : g_plain
      assign accept = 1'b1;
    end
  endgenerate

  // write path is independent of the mask (R4)
  always_comb begin
    d = q;
    if (wr_en && accept) d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign eff_o = masked ? '0 : q;

  // R5: storage untouched without a write, whatever the mask does
  p_field_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/retaddr_reg.sv
module retaddr_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:1] wr_val,
  input  logic            align16,
  output logic [XLEN-1:0] eff_o
);
  logic [XLEN-1:1] q, d;

  always_comb begin
    d = q;
    if (wr_en) d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign eff_o = {q[XLEN-1:2], q[1] & align16, 1'b0};

  // R4/R8: a write lands in storage, bit 1 included, even when hidden
  p_ret_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_val));
  // R7: bit 0 of the visible value is never set
  p_bit0_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eff_o[0] == 1'b0);
endmodule

// File: rtl/maskable_csr_unit.sv
module maskable_csr_unit #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [1:0]      mode_eff_o,
  output logic            flag_eff_o,
  output logic [XLEN-1:0] retpc_eff_o
);
  import csr_mask_pkg::*;

  localparam int unsigned PAD_EN   = XLEN - NUM_EN;
  localparam int unsigned PAD_DATA = XLEN - FLAG_BIT - 1;

  logic [NUM_EN-1:0] en;
  logic              we_en, we_data, we_ret;

  assign we_en   = csr_we && (csr_addr == A_ENABLE);
  assign we_data = csr_we && (csr_addr == A_DATA);
  assign we_ret  = csr_we && (csr_addr == A_RETPC);

  mask_ctrl #(.N(NUM_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(we_en),
    .wr_val(csr_wdata[NUM_EN-1:0]), .en_o(en));

  hidden_field #(.W(MODE_W), .LEGALIZE(1'b1)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(we_data),
    .wr_val(csr_wdata[MODE_W-1:0]), .masked(!en[EN_MODE]),
    .eff_o(mode_eff_o));

  hidden_field #(.W(1), .LEGALIZE(1'b0)) u_flag (
    .clk(clk), .rst_n(rst_n), .wr_en(we_data),
    .wr_val(csr_wdata[FLAG_BIT]), .masked(!en[EN_FLAG]),
    .eff_o(flag_eff_o));

  retaddr_reg #(.XLEN(XLEN)) u_ret (
    .clk(clk), .rst_n(rst_n), .wr_en(we_ret),
    .wr_val(csr_wdata[XLEN-1:1]), .align16(en[EN_CMP]),
    .eff_o(retpc_eff_o));

  always_comb begin
    unique case (csr_addr)
      A_ENABLE: csr_rdata = {{PAD_EN{1'b0}}, en};
      A_DATA:   csr_rdata = {{PAD_DATA{1'b0}}, flag_eff_o, mode_eff_o};
      A_RETPC:  csr_rdata = retpc_eff_o;
      default:  csr_rdata = '0;
    endcase
  end

  // R3: a cleared enable shows zero on the exported field
  p_mode_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en[EN_MODE] |-> mode_eff_o == '0);
  p_flag_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en[EN_FLAG] |-> flag_eff_o == 1'b0);
  // R8: compressed support off hides return-address bit 1
  p_bit1_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en[EN_CMP] |-> retpc_eff_o[1] == 1'b0);
  // R9: the unimplemented address reads zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr == A_UNUSED |-> csr_rdata == '0);
endmodule

// File: tb/sim_maskable_csr_unit.sv
module sim_maskable_csr_unit;
  logic        clk, rst_n, csr_we;
  logic [1:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata, retpc_eff_o;
  logic [1:0]  mode_eff_o;
  logic        flag_eff_o;

  maskable_csr_unit #(.XLEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mode_eff_o(mode_eff_o),
    .flag_eff_o(flag_eff_o), .retpc_eff_o(retpc_eff_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(posedge clk); #2;
    csr_addr = a; csr_we = 1'b1; csr_wdata = v;
  endtask

  // sel: 0 rdata, 1 mode, 2 flag, 3 return address
  task automatic chk(input int sel, input logic [1:0] a,
                     input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #2;
    csr_addr = a; csr_we = 1'b0; csr_wdata = '0;
    it.sel = sel; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.sel)
        1: act = {30'b0, mode_eff_o};
        2: act = {31'b0, flag_eff_o};
        3: act = retpc_eff_o;
        default: act = csr_rdata;
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = 2'd0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk(0, 2'd0, 32'd7, "R1 enable reset");
    chk(0, 2'd1, 32'd0, "R1 data reset");
    chk(0, 2'd2, 32'd0, "R1 retpc reset");
    chk(3, 2'd2, 32'd0, "R1 retpc export reset");

    wr(2'd1, 32'd7);
    chk(0, 2'd1, 32'd7, "R2 data write");
    chk(1, 2'd1, 32'd3, "R2 mode export");
    chk(2, 2'd1, 32'd1, "R2 flag export");
    wr(2'd1, 32'd2);
    chk(0, 2'd1, 32'd3, "R6 illegal mode ignored, flag cleared");

    wr(2'd0, 32'd4);
    chk(0, 2'd0, 32'd4, "R10 enable readback");
    chk(0, 2'd1, 32'd0, "R3 masked data reads zero");
    chk(1, 2'd1, 32'd0, "R3 mode export masked");
    wr(2'd1, 32'd5);
    chk(0, 2'd1, 32'd0, "R3 masked after write");
    chk(2, 2'd1, 32'd0, "R3 flag export masked");
    wr(2'd1, 32'd6);
    wr(2'd0, 32'd7);
    chk(0, 2'd1, 32'd5, "R4 R6 hidden write revealed, masked legalized");

    wr(2'd0, 32'd4);
    chk(0, 2'd1, 32'd0, "R5 remask");
    wr(2'd0, 32'hFFFF_FFFF);
    chk(0, 2'd1, 32'd5, "R5 value kept across toggle");
    chk(0, 2'd0, 32'd7, "R10 upper enable bits read zero");

    wr(2'd2, 32'hDEAD_BEEF);
    chk(0, 2'd2, 32'hDEAD_BEEE, "R7 bit0 hardwired");
    chk(3, 2'd2, 32'hDEAD_BEEE, "R7 export bit0");
    wr(2'd0, 32'd3);
    chk(0, 2'd2, 32'hDEAD_BEEC, "R8 bit1 masked");
    chk(3, 2'd2, 32'hDEAD_BEEC, "R8 export bit1 masked");
    wr(2'd2, 32'h1234_5677);
    chk(0, 2'd2, 32'h1234_5674, "R8 masked write");
    wr(2'd0, 32'd7);
    chk(0, 2'd2, 32'h1234_5676, "R8 R4 bit1 reappears");

    wr(2'd3, 32'hFFFF_FFFF);
    chk(0, 2'd3, 32'd0, "R9 unimplemented reads zero");
    chk(0, 2'd0, 32'd7, "R9 enable unchanged");
    chk(0, 2'd1, 32'd5, "R9 data unchanged");
    chk(0, 2'd2, 32'h1234_5676, "R9 retpc unchanged");

    @(posedge clk); #2;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule